// File: doc/BRIEF.md
# Two-Context Thread Slot Controller

Each core of a migration-based multicore keeps two hardware thread contexts: a home slot for the thread that belongs to this core, and one visitor slot for a thread that has migrated in from elsewhere. This controller decides where an arriving thread goes and when it may be let in. When the visitor slot is already taken, it sends the current visitor back to the core that visitor belongs to. It also chooses which resident thread issues into the single-issue pipeline on each cycle. Moving the register file, routing the network and running the cache are handled by neighbouring blocks.

A thread is identified by its home core number. An arrival whose home is this core goes to the home slot. Any other arrival goes to the visitor slot. A visitor that has to leave is held back until all of its memory and remote-access replies have come in and it has retired at least one instruction. This keeps migration free of deadlock and livelock. On the shared outgoing migration port, evictions are served before departures caused by core misses. An arrival that cannot be admitted yet is held on a valid/ready handshake; no storage is allocated for it.

Top module: `ctx_slot_mgr`

## Requirements
- R1: After reset, the home slot holds this core's own thread (id MY_CORE) and the visitor slot is empty. So issue_valid=1, issue_slot=0 and issue_thread=MY_CORE, with out_valid=0 and in_ready=0 while in_valid=0.
- R2: An arrival with in_native_core==MY_CORE is accepted in the same cycle when the home slot is empty and is placed in slot 0.
- R3: An arrival from another core goes to slot 1. If slot 1 is occupied, its occupant is first sent out with out_is_evict=1, and both out_dest and out_thread equal that occupant's home core.
- R4: A visitor with a DRAM request or a remote-access request that has not yet been answered is not evicted, and it does not issue, until every such reply has arrived.
- R5: A visitor that has not retired an instruction since it was admitted is not evicted.
- R6: When both slots can run, issue alternates between slot 0 and slot 1 every cycle.
- R7: While an eviction is waiting on the outgoing port, miss_req_ready is 0 and the port carries the eviction.
- R8: When only one slot can run, that slot issues on every cycle.
- R9: A core-miss departure completes on a miss_req_valid/miss_req_ready handshake, and the slot it leaves is empty from the next cycle.
- R10: While an arriving visitor waits for the current visitor to drain or leave, in_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An arriving thread is offered |
| in_native_core | input | CORE_W | Home core (identity) of the arriving thread |
| in_ready | output | 1 | The arrival is accepted this cycle |
| issue_valid | output | 1 | A slot issues this cycle |
| issue_slot | output | 1 | Issuing slot (0 home, 1 visitor) |
| issue_thread | output | CORE_W | Identity of the issuing thread |
| retire_valid | input | 1 | An instruction retired |
| retire_slot | input | 1 | Slot of the retired instruction |
| dram_req_valid | input | 1 | A DRAM request was sent |
| dram_req_slot | input | 1 | Slot that sent the DRAM request |
| dram_rsp_valid | input | 1 | A DRAM reply arrived |
| dram_rsp_slot | input | 1 | Slot the DRAM reply belongs to |
| ra_req_valid | input | 1 | A remote-access request was sent |
| ra_req_slot | input | 1 | Slot that sent the remote-access request |
| ra_rsp_valid | input | 1 | A remote-access reply arrived |
| ra_rsp_slot | input | 1 | Slot the remote-access reply belongs to |
| miss_req_valid | input | 1 | A slot asks to migrate away after a core miss |
| miss_req_slot | input | 1 | Slot that is leaving |
| miss_req_dest | input | CORE_W | Destination core of the core-miss migration |
| miss_req_ready | output | 1 | The core-miss departure is taken this cycle |
| out_valid | output | 1 | The outgoing migration port carries a thread |
| out_ready | input | 1 | The network accepts the outgoing thread |
| out_is_evict | output | 1 | The outgoing thread is an eviction |
| out_dest | output | CORE_W | Destination core of the outgoing thread |
| out_thread | output | CORE_W | Identity of the outgoing thread |

## Verification
Acceptance of an arrival (in_ready) and the outgoing port are combinational in the current state, so the bench samples them one nanosecond after the falling edge, before the edge that completes the handshake. A newly placed thread becomes visible on issue_thread in the cycle after that edge. When the visitor is already drained, the eviction appears two cycles after the arrival is first offered: one edge to enter the wait state and one more to reach the send state. The new visitor is accepted in the cycle after the eviction is taken. The bench waits on these events inside bounded windows. During every "must not happen" window it samples every cycle, so an eviction or an acceptance that comes too early is caught in the cycle where it shows up.

// File: rtl/ctx_pkg.sv
// Shared definitions for the two-context slot controller.
// Assumes slot 0 is the home context and slot 1 the visitor context.
package ctx_pkg;
    localparam int NUM_SLOTS = 2;
    localparam logic SLOT_HOME  = 1'b0;
    localparam logic SLOT_VISIT = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_DRAIN = 2'd1,
        ST_EVICT_SEND = 2'd2,
        ST_ADMIT      = 2'd3
    } adm_state_e;
endpackage

// File: rtl/ctx_outst_ctr.sv
// Counts the outstanding requests of one kind for one slot.
// Assumes at most one request and one reply per cycle. A reply arriving
// while the count is zero is ignored, and the count saturates at its maximum.
module ctx_outst_ctr #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic is_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Purpose: track requests still waiting for their reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: report when every request of this kind has been answered.
    always_comb is_zero = (cnt_q == '0);
endmodule

// File: rtl/ctx_rr_pick.sv
// Picks the slot that issues this cycle. When both slots can run, it
// alternates between them; when only one can run, that one is picked.
// Assumes the pipeline takes the picked slot on every cycle.
module ctx_rr_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] run,
    output logic       grant_valid,
    output logic       grant_slot
);
    logic last_q;

    // Purpose: choose the slot that issues this cycle.
    always_comb begin
        grant_valid = |run;
        if (&run) grant_slot = ~last_q;
        else      grant_slot = run[1];
    end

    // Purpose: remember which slot issued last.
    always_ff @(posedge clk) begin
        if (!rst_n)           last_q <= 1'b1;
        else if (grant_valid) last_q <= grant_slot;
    end

    // R6: with both slots runnable, consecutive grants differ.
    a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (&run && grant_valid) |=> (&run) |-> (grant_slot != $past(grant_slot)));
endmodule

// File: rtl/ctx_admit_fsm.sv
// Admission and eviction sequencer for the visitor slot.
// Admits home-bound arrivals directly when the home slot is free.
// For a visitor-bound arrival that meets an occupied visitor slot, it
// waits for the occupant to drain, sends the eviction, then admits.
// Assumes in_valid and in_native_core stay stable until in_ready.
module ctx_admit_fsm
    import ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_is_home,
    input  logic       home_busy,
    input  logic       visit_busy,
    input  logic       visit_drained,
    input  logic       out_ready,
    output logic       in_ready,
    output logic       admit_home,
    output logic       admit_visit,
    output logic       evict_valid,
    output logic       evict_done,
    output adm_state_e state
);
    adm_state_e state_q, state_d;

    // Purpose: drive the handshakes and the next state.
    always_comb begin
        state_d     = state_q;
        in_ready    = 1'b0;
        evict_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = in_valid && (in_is_home ? !home_busy : !visit_busy);
                if (in_valid && !in_is_home && visit_busy) state_d = ST_WAIT_DRAIN;
            end
            ST_WAIT_DRAIN: begin
                if (!visit_busy)        state_d = ST_ADMIT;
                else if (visit_drained) state_d = ST_EVICT_SEND;
            end
            ST_EVICT_SEND: begin
                evict_valid = visit_drained;
                if (!visit_drained)  state_d = ST_WAIT_DRAIN;
                else if (out_ready)  state_d = ST_ADMIT;
            end
            ST_ADMIT: begin
                in_ready = in_valid && !in_is_home;
                if (!in_valid || in_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        evict_done  = evict_valid && out_ready;
        admit_home  = in_valid && in_ready && in_is_home;
        admit_visit = in_valid && in_ready && !in_is_home;
    end

    // Purpose: hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb state = state_q;

    // R10: no visitor is accepted while the occupant drains or leaves.
    a_r10_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_DRAIN || state_q == ST_EVICT_SEND) |-> !in_ready);
    // R3: a visitor is only admitted into an empty visitor slot.
    a_r3_admit_empty: assert property (@(posedge clk) disable iff (!rst_n)
        admit_visit |-> !visit_busy);
endmodule

// File: rtl/ctx_slot_mgr.sv
// Top level of the two-context slot controller.
// Holds the occupancy and home core of each slot, the per-slot outstanding
// request counters and retire counters, the issue picker and the shared
// outgoing migration port (evictions before core-miss departures).
// Assumes a thread is named by its home core, the home thread is resident
// at reset, and request/reply/retire pulses name occupied slots.
module ctx_slot_mgr
    import ctx_pkg::*;
#(
    parameter int          CORE_W  = 4,
    parameter logic [CORE_W-1:0] MY_CORE = 4'd5,
    parameter int          OUTST_W = 3,
    parameter int          RET_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CORE_W-1:0] in_native_core,
    output logic              in_ready,
    output logic              issue_valid,
    output logic              issue_slot,
    output logic [CORE_W-1:0] issue_thread,
    input  logic              retire_valid,
    input  logic              retire_slot,
    input  logic              dram_req_valid,
    input  logic              dram_req_slot,
    input  logic              dram_rsp_valid,
    input  logic              dram_rsp_slot,
    input  logic              ra_req_valid,
    input  logic              ra_req_slot,
    input  logic              ra_rsp_valid,
    input  logic              ra_rsp_slot,
    input  logic              miss_req_valid,
    input  logic              miss_req_slot,
    input  logic [CORE_W-1:0] miss_req_dest,
    output logic              miss_req_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_is_evict,
    output logic [CORE_W-1:0] out_dest,
    output logic [CORE_W-1:0] out_thread
);
    localparam int NUM_KINDS = 2;
    localparam logic [RET_W-1:0] RET_MAX = {RET_W{1'b1}};

    logic [NUM_SLOTS-1:0]   busy_q;
    logic [CORE_W-1:0]      home_q [NUM_SLOTS];
    logic [RET_W-1:0]       ret_q  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]   quiet;
    logic [NUM_SLOTS-1:0]   run;
    logic [NUM_KINDS-1:0]   req_v, req_s, rsp_v, rsp_s;
    logic                   in_is_home, admit_home, admit_visit;
    logic                   evict_valid, evict_done, visit_drained, visit_freeze;
    logic                   miss_fire;
    logic [NUM_SLOTS-1:0]   admit_v, leave_v;
    adm_state_e             state;

    // Purpose: gather request and reply pulses by kind (0 DRAM, 1 remote).
    always_comb begin
        req_v = {ra_req_valid, dram_req_valid};
        req_s = {ra_req_slot,  dram_req_slot};
        rsp_v = {ra_rsp_valid, dram_rsp_valid};
        rsp_s = {ra_rsp_slot,  dram_rsp_slot};
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [NUM_KINDS-1:0] kind_zero;
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            ctx_outst_ctr #(.CNT_W(OUTST_W)) u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (req_v[k] && (req_s[k] == 1'(s))),
                .dec     (rsp_v[k] && (rsp_s[k] == 1'(s))),
                .is_zero (kind_zero[k])
            );
        end
        always_comb quiet[s] = &kind_zero;

        // Purpose: count retired instructions since this slot was filled.
        always_ff @(posedge clk) begin
            if (!rst_n)                    ret_q[s] <= '0;
            else if (admit_v[s])           ret_q[s] <= '0;
            else if (retire_valid && (retire_slot == 1'(s)) && ret_q[s] != RET_MAX)
                                           ret_q[s] <= ret_q[s] + 1'b1;
        end

        // Purpose: track occupancy and the resident thread's home core.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[s] <= (s == 0);
                home_q[s] <= (s == 0) ? MY_CORE : '0;
            end else if (admit_v[s]) begin
                busy_q[s] <= 1'b1;
                home_q[s] <= in_native_core;
            end else if (leave_v[s]) begin
                busy_q[s] <= 1'b0;
            end
        end
    end

    assign in_is_home = (in_native_core == MY_CORE);

    ctx_admit_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_is_home    (in_is_home),
        .home_busy     (busy_q[SLOT_HOME]),
        .visit_busy    (busy_q[SLOT_VISIT]),
        .visit_drained (visit_drained),
        .out_ready     (out_ready),
        .in_ready      (in_ready),
        .admit_home    (admit_home),
        .admit_visit   (admit_visit),
        .evict_valid   (evict_valid),
        .evict_done    (evict_done),
        .state         (state)
    );

    // Purpose: derive drain and runnable conditions of each slot.
    always_comb begin
        visit_drained = quiet[SLOT_VISIT] && (ret_q[SLOT_VISIT] != '0);
        visit_freeze  = (state == ST_WAIT_DRAIN || state == ST_EVICT_SEND)
                        && (ret_q[SLOT_VISIT] != '0);
        run[SLOT_HOME]  = busy_q[SLOT_HOME]  && quiet[SLOT_HOME];
        run[SLOT_VISIT] = busy_q[SLOT_VISIT] && quiet[SLOT_VISIT] && !visit_freeze;
    end

    ctx_rr_pick u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .grant_valid (issue_valid),
        .grant_slot  (issue_slot)
    );

    assign issue_thread = home_q[issue_slot];

    // Purpose: share the outgoing port, eviction first.
    always_comb begin
        miss_req_ready = out_ready && !evict_valid && busy_q[miss_req_slot];
        miss_fire      = miss_req_valid && miss_req_ready;
        out_is_evict   = evict_valid;
        out_valid      = evict_valid || (miss_req_valid && busy_q[miss_req_slot]);
        out_dest       = evict_valid ? home_q[SLOT_VISIT] : miss_req_dest;
        out_thread     = evict_valid ? home_q[SLOT_VISIT] : home_q[miss_req_slot];
        admit_v        = {admit_visit, admit_home};
        leave_v[SLOT_HOME]  = miss_fire && (miss_req_slot == SLOT_HOME);
        leave_v[SLOT_VISIT] = evict_done || (miss_fire && (miss_req_slot == SLOT_VISIT));
    end

    // R4: an eviction never leaves with replies still owed.
    a_r4_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_evict) |-> quiet[SLOT_VISIT]);
    // R5: an eviction requires a retired instruction in the visitor slot.
    a_r5_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_evict) |-> (ret_q[SLOT_VISIT] != '0));
    // R7: a waiting eviction blocks core-miss departures.
    a_r7_evict_first: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_evict) |-> !miss_req_ready);
    // R8: a single runnable slot always issues.
    a_r8_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(run) == 1) |-> issue_valid);
    // R2: a home-bound arrival fills the home slot.
    a_r2_home_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_is_home) |=> busy_q[SLOT_HOME]);
    // R9: a core-miss departure empties its slot.
    a_r9_leave_home: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_fire && miss_req_slot == SLOT_HOME) |=> !busy_q[SLOT_HOME]);
    // R3: evictions are addressed to the evicted thread's own home.
    a_r3_home_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_evict) |-> (out_dest == out_thread && out_dest != MY_CORE));
endmodule

// File: tb/ctx_slot_mgr_tb_top.sv
`timescale 1ns/1ps
module ctx_slot_mgr_tb_top;
    localparam int CW = 4;
    localparam logic [CW-1:0] ME = 4'd5;
    localparam int NV = 4;
    localparam logic [CW-1:0] VEC [NV] = '{4'd3, 4'd7, 4'd9, 4'd2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_ready;
    logic [CW-1:0] in_native_core = '0;
    logic issue_valid, issue_slot;
    logic [CW-1:0] issue_thread;
    logic retire_valid = 0, retire_slot = 0;
    logic dram_req_valid = 0, dram_req_slot = 0, dram_rsp_valid = 0, dram_rsp_slot = 0;
    logic ra_req_valid = 0, ra_req_slot = 0, ra_rsp_valid = 0, ra_rsp_slot = 0;
    logic miss_req_valid = 0, miss_req_slot = 0, miss_req_ready;
    logic [CW-1:0] miss_req_dest = '0;
    logic out_valid, out_ready = 1, out_is_evict;
    logic [CW-1:0] out_dest, out_thread;
    logic auto_ret = 0, man_ret = 0, man_slot = 0;
    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    ctx_slot_mgr #(.CORE_W(CW), .MY_CORE(ME)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_native_core(in_native_core),
        .in_ready(in_ready), .issue_valid(issue_valid), .issue_slot(issue_slot),
        .issue_thread(issue_thread), .retire_valid(retire_valid), .retire_slot(retire_slot),
        .dram_req_valid(dram_req_valid), .dram_req_slot(dram_req_slot),
        .dram_rsp_valid(dram_rsp_valid), .dram_rsp_slot(dram_rsp_slot),
        .ra_req_valid(ra_req_valid), .ra_req_slot(ra_req_slot),
        .ra_rsp_valid(ra_rsp_valid), .ra_rsp_slot(ra_rsp_slot),
        .miss_req_valid(miss_req_valid), .miss_req_slot(miss_req_slot),
        .miss_req_dest(miss_req_dest), .miss_req_ready(miss_req_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_is_evict(out_is_evict),
        .out_dest(out_dest), .out_thread(out_thread));

    // Pipeline model: what issued in a cycle retires at that cycle's edge.
    always @(negedge clk) begin
        #1;
        retire_valid <= (auto_ret && issue_valid) || man_ret;
        retire_slot  <= man_ret ? man_slot : issue_slot;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    // Keeps in_valid high until it is accepted; records any eviction seen.
    task automatic finish_arrival(input string req, output bit ev, output int ev_dest);
        bit got = 0;
        ev = 0; ev_dest = -1;
        for (int k = 0; k < 60 && !got; k++) begin
            if (out_valid && out_is_evict && out_ready) begin
                ev = 1; ev_dest = int'(out_dest);
                chk({req, " thread"}, int'(out_thread), int'(out_dest));
            end
            if (in_ready) got = 1;
            settle();
        end
        chk({req, " accepted"}, int'(got), 1);
        in_valid = 0;
    endtask

    task automatic arrive(input logic [CW-1:0] c, input string req, output bit ev, output int ev_dest);
        in_native_core = c; in_valid = 1; #0.1;
        finish_arrival(req, ev, ev_dest);
    endtask

    task automatic hold_quiet(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            chk({req, " no eviction"}, int'(out_valid), 0);
            chk("R10 ready held", int'(in_ready), 0);
            settle();
        end
    endtask

    // R4: a visitor owing a reply of the given kind stays until it arrives.
    task automatic drain_test(input bit ra, input logic [CW-1:0] c, input logic [CW-1:0] prev);
        bit ev; int d;
        if (ra) begin ra_req_valid = 1; ra_req_slot = 1; end
        else    begin dram_req_valid = 1; dram_req_slot = 1; end
        settle();
        ra_req_valid = 0; dram_req_valid = 0;
        in_native_core = c; in_valid = 1; #0.1;
        for (int k = 0; k < 6; k++) begin
            chk("R4 visitor stalled", int'(issue_valid && issue_slot), 0);
            chk("R4 no eviction", int'(out_valid), 0);
            chk("R10 ready held", int'(in_ready), 0);
            settle();
        end
        if (ra) begin ra_rsp_valid = 1; ra_rsp_slot = 1; end
        else    begin dram_rsp_valid = 1; dram_rsp_slot = 1; end
        settle();
        ra_rsp_valid = 0; dram_rsp_valid = 0;
        finish_arrival("R4 drained", ev, d);
        chk("R4 evicted", int'(ev), 1);
        chk("R3 evict dest", d, int'(prev));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ev; int d;
        repeat (3) settle();
        // R1: reset state.
        chk("R1 issue_valid", int'(issue_valid), 1);
        chk("R1 issue_slot", int'(issue_slot), 0);
        chk("R1 issue_thread", int'(issue_thread), int'(ME));
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 0);
        rst_n = 1;
        settle();
        // R8: home thread alone issues every cycle.
        for (int k = 0; k < 4; k++) begin
            chk("R8 home every cycle", int'(issue_valid && !issue_slot), 1);
            settle();
        end
        auto_ret = 1;
        // Vector table: successive visitors, each evicting the previous one.
        for (int i = 0; i < NV; i++) begin
            logic [1:0] seen;
            arrive(VEC[i], "R3 arrival", ev, d);
            chk("R3 eviction happened", int'(ev), (i > 0) ? 1 : 0);
            if (i > 0) chk("R3 evict dest", d, int'(VEC[i-1]));
            seen = '0;
            for (int k = 0; k < 4; k++) begin
                if (k > 0) chk("R6 alternation", int'(issue_slot), int'(!seen[0]));
                seen[0] = issue_slot;
                if (issue_slot) chk("R3 visitor thread", int'(issue_thread), int'(VEC[i]));
                settle();
            end
        end
        drain_test(0, 4'd11, VEC[NV-1]);
        repeat (3) settle();
        drain_test(1, 4'd12, 4'd11);
        repeat (3) settle();
        // R5: a visitor without a retirement cannot be evicted.
        auto_ret = 0;
        arrive(4'd13, "R5 arrival", ev, d);
        chk("R5 prev evicted", d, 12);
        in_native_core = 4'd14; in_valid = 1; #0.1;
        hold_quiet("R5", 6);
        man_ret = 1; man_slot = 1;
        settle();
        man_ret = 0;
        finish_arrival("R5 after retire", ev, d);
        chk("R5 evict dest", d, 13);
        // R7: eviction outranks a core-miss departure.
        auto_ret = 1;
        repeat (3) settle();
        out_ready = 0;
        miss_req_valid = 1; miss_req_slot = 0; miss_req_dest = 4'd1;
        in_native_core = 4'd15; in_valid = 1; #0.1;
        begin
            bit seen_ev = 0;
            for (int k = 0; k < 20 && !seen_ev; k++) begin
                if (out_valid && out_is_evict) seen_ev = 1; else settle();
            end
            chk("R7 eviction offered", int'(seen_ev), 1);
        end
        chk("R7 miss blocked", int'(miss_req_ready), 0);
        chk("R7 evict dest", int'(out_dest), 14);
        out_ready = 1;
        settle();
        chk("R7 miss now offered", int'(out_is_evict), 0);
        chk("R7 miss ready", int'(miss_req_ready), 1);
        chk("R9 miss dest", int'(out_dest), 1);
        chk("R9 miss thread", int'(out_thread), int'(ME));
        chk("R3 admit after evict", int'(in_ready), 1);
        settle();
        in_valid = 0; miss_req_valid = 0;
        // R9 / R8: home slot emptied, visitor issues alone.
        for (int k = 0; k < 4; k++) begin
            chk("R9 visitor alone", int'(issue_valid && issue_slot), 1);
            chk("R9 visitor id", int'(issue_thread), 15);
            settle();
        end
        // R2: home thread returns straight into slot 0.
        in_native_core = ME; in_valid = 1; #0.1;
        chk("R2 immediate accept", int'(in_ready), 1);
        settle();
        in_valid = 0;
        begin
            bit home_seen = 0;
            for (int k = 0; k < 2; k++) begin
                if (issue_valid && !issue_slot && issue_thread == ME) home_seen = 1;
                settle();
            end
            chk("R2 home issues", int'(home_seen), 1);
        end
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule